// File: doc/BRIEF.md
# Strided Tile Transfer Engine

The engine moves one tile at a time between a row-addressed tile register file and a memory request port. A command gives an operation, a tile index, a base address and a row stride. The row count and the bytes per row come from the shape inputs of the configuration controller, which the engine samples when it accepts the command. Row `r` of a transfer always uses the address `base + r * stride`, so software can lay the rows out with any spacing it likes.

A load reads one memory row per configured row and writes each returned row into the tile. Any tile row past the configured count is cleared, and so is any byte past the configured row width. The streaming load does the same work but marks its reads as unlikely to be reused. A store reads the tile rows and issues one masked write per row. A clear command zeroes the configured rows of a tile and makes no memory traffic. When the shape is not valid, the command is refused with an error pulse.

Top module: `tile_xfer_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_ready` is 1 and `mem_req_valid`, `tf_wr_en`, `tf_rd_en`, `xfer_done` and `xfer_err` are all 0.
- R2: A load (`cmd_op` 0) issues exactly `rows` read requests (`mem_req_write` 0), in row order. Row r uses address `base + r*stride`. `mem_req_be` bit i is 1 exactly when i < bytes-per-row.
- R3: On a load, tile row r (r < rows) receives the data returned for row r. Byte i of the row is `mem_rsp_data[8i+7:8i]` when i < bytes-per-row, and 0 otherwise.
- R4: On a load, every tile row at index rows or above is written with zero.
- R5: A streaming load (`cmd_op` 1) behaves like a load, except that `mem_req_hint` is 1 on its requests. `mem_req_hint` is 0 on all other requests.
- R6: A store (`cmd_op` 2) issues exactly `rows` write requests (`mem_req_write` 1) at `base + r*stride`. The write data holds tile row r with the bytes past bytes-per-row forced to zero, and the byte enables follow the rule of R2.
- R7: A clear (`cmd_op` 3) zeroes tile rows 0 to rows-1. It leaves the rows above unchanged and issues no memory request.
- R8: A command accepted while `cfg_valid` is 0, or while the row count or the bytes per row is 0, causes a one-cycle `xfer_err` pulse in the cycle after acceptance. Such a command causes no memory request, no tile write and no `xfer_done`.
- R9: `xfer_done` is a one-cycle pulse in the cycle after the last event of the command: the last read response, the last accepted write, or the last clear write.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request holds its valid, address, byte enables, data and direction into the next cycle.
- R11: `cmd_ready` is 0 while a command is in progress. A command offered in that time is not taken and has no effect.
- R12: Address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken on valid and ready |
| cmd_op | input | 2 | 0 load, 1 streaming load, 2 store, 3 clear |
| cmd_tile | input | TILE_W | Tile index |
| cmd_base | input | ADDR_W | Address of row 0 |
| cmd_stride | input | ADDR_W | Address step between rows |
| cfg_valid | input | 1 | Configuration present |
| cfg_rows | input | RCNT_W | Configured row count (1..MAX_ROWS) |
| cfg_bytes | input | BCNT_W | Configured bytes per row (1..ROW_BYTES) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_hint | output | 1 | Low-reuse hint for streaming loads |
| mem_req_addr | output | ADDR_W | Row address |
| mem_req_be | output | ROW_BYTES | Byte enables |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | DATA_W | Read response data |
| tf_wr_en | output | 1 | Tile row write enable |
| tf_wr_tile | output | TILE_W | Tile written |
| tf_wr_row | output | ROW_W | Row written |
| tf_wr_data | output | DATA_W | Row write data |
| tf_rd_en | output | 1 | Tile row read enable (data one cycle later) |
| tf_rd_tile | output | TILE_W | Tile read |
| tf_rd_row | output | ROW_W | Row read |
| tf_rd_data | input | DATA_W | Row read data |
| xfer_done | output | 1 | Command completed |
| xfer_err | output | 1 | Command refused |

## Verification
The hardest case to reach is a command that arrives while the engine is busy, because the engine drops `cmd_ready` as soon as it accepts a command. The stimulus starts a short load with the tail-row clears still ahead of it, then offers a clear of another tile for several cycles during that load. Afterwards it checks that the other tile is unchanged and that only the load's requests appeared. The memory model applies pseudo-random backpressure and response delay, which keeps requests stalled often enough to test the hold rule. A vector with a base near the top of the address space tests the wrap of the row address.

// File: rtl/tile_xfer_pkg.sv
package tile_xfer_pkg;

  typedef enum logic [1:0] {
    OP_LOAD    = 2'd0,
    OP_LOAD_NT = 2'd1,
    OP_STORE   = 2'd2,
    OP_ZERO    = 2'd3
  } xfer_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,   // zero the tail rows of a load
    ST_REQ,    // read request for row_q
    ST_WAIT,   // wait for read response
    ST_RD,     // tile row read for store
    ST_LAT,    // capture tile row
    ST_SWR,    // write request for row_q
    ST_CLR     // clear one row
  } xfer_state_e;

endpackage

// File: rtl/tile_xfer_mask.sv
module tile_xfer_mask #(
  parameter int ROW_BYTES = 64,
  localparam int BCNT_W = $clog2(ROW_BYTES + 1),
  localparam int DATA_W = ROW_BYTES * 8
) (
  input  logic [BCNT_W-1:0]    bytes,
  output logic [ROW_BYTES-1:0] be,
  output logic [DATA_W-1:0]    bits
);

  function automatic logic lane_on(input int lane, input logic [BCNT_W-1:0] n);
    return lane < int'(n);
  endfunction

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_lane
    assign be[g]          = lane_on(g, bytes);
    assign bits[g*8 +: 8] = {8{be[g]}};
  end

  always_comb begin
    if (bytes <= BCNT_W'(ROW_BYTES)) begin
      assert_mask_count_R2: assert ($countones(be) == int'(bytes));
    end
  end

endmodule

// File: rtl/tile_xfer_addr.sv
module tile_xfer_addr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride_in,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_q, stride_q;

  // modulo 2^ADDR_W by width
  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] s);
    return a + s;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stride_q <= '0;
    end else if (load) begin
      addr_q   <= base;
      stride_q <= stride_in;
    end else if (step) begin
      addr_q   <= next_addr(addr_q, stride_q);
    end
  end

  assign addr = addr_q;

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !step |=> $stable(addr));

endmodule

// File: rtl/tile_xfer_engine.sv
module tile_xfer_engine
  import tile_xfer_pkg::*;
#(
  parameter int NUM_TILES = 8,
  parameter int MAX_ROWS  = 16,
  parameter int ROW_BYTES = 64,
  parameter int ADDR_W    = 32,
  localparam int TILE_W = $clog2(NUM_TILES),
  localparam int ROW_W  = $clog2(MAX_ROWS),
  localparam int RCNT_W = $clog2(MAX_ROWS + 1),
  localparam int BCNT_W = $clog2(ROW_BYTES + 1),
  localparam int DATA_W = ROW_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [1:0]           cmd_op,
  input  logic [TILE_W-1:0]    cmd_tile,
  input  logic [ADDR_W-1:0]    cmd_base,
  input  logic [ADDR_W-1:0]    cmd_stride,
  input  logic                 cfg_valid,
  input  logic [RCNT_W-1:0]    cfg_rows,
  input  logic [BCNT_W-1:0]    cfg_bytes,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_write,
  output logic                 mem_req_hint,
  output logic [ADDR_W-1:0]    mem_req_addr,
  output logic [ROW_BYTES-1:0] mem_req_be,
  output logic [DATA_W-1:0]    mem_req_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [DATA_W-1:0]    mem_rsp_data,
  output logic                 tf_wr_en,
  output logic [TILE_W-1:0]    tf_wr_tile,
  output logic [ROW_W-1:0]     tf_wr_row,
  output logic [DATA_W-1:0]    tf_wr_data,
  output logic                 tf_rd_en,
  output logic [TILE_W-1:0]    tf_rd_tile,
  output logic [ROW_W-1:0]     tf_rd_row,
  input  logic [DATA_W-1:0]    tf_rd_data,
  output logic                 xfer_done,
  output logic                 xfer_err
);

  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(MAX_ROWS - 1);

  xfer_state_e         state;
  xfer_op_e            op_q;
  xfer_op_e            cmd_op_e;
  logic [TILE_W-1:0]   tile_q;
  logic [RCNT_W-1:0]   rows_q;
  logic [BCNT_W-1:0]   bpr_q;
  logic [ROW_W-1:0]    row_q;
  logic [DATA_W-1:0]   wbuf;
  logic                done_q, err_q;

  // named internal events
  logic                cmd_fire, req_fire, rsp_take, last_row, row_step, shape_bad;
  logic [ROW_BYTES-1:0] row_be;
  logic [DATA_W-1:0]   row_bits;
  logic [ADDR_W-1:0]   row_addr;

  function automatic logic shape_invalid(input logic              cv,
                                         input logic [RCNT_W-1:0] r,
                                         input logic [BCNT_W-1:0] b);
    return !cv || (r == '0) || (b == '0) ||
           (r > RCNT_W'(MAX_ROWS)) || (b > BCNT_W'(ROW_BYTES));
  endfunction

  function automatic logic is_last(input logic [ROW_W-1:0]  r,
                                   input logic [RCNT_W-1:0] n);
    return (RCNT_W'(r) + RCNT_W'(1)) == n;
  endfunction

  assign cmd_op_e  = xfer_op_e'(cmd_op);
  assign cmd_ready = (state == ST_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign shape_bad = shape_invalid(cfg_valid, cfg_rows, cfg_bytes);
  assign req_fire  = mem_req_valid && mem_req_ready;
  assign rsp_take  = (state == ST_WAIT) && mem_rsp_valid;
  assign last_row  = is_last(row_q, rows_q);
  assign row_step  = (rsp_take || ((state == ST_SWR) && req_fire)) && !last_row;

  tile_xfer_mask #(.ROW_BYTES(ROW_BYTES)) u_mask (
    .bytes (bpr_q),
    .be    (row_be),
    .bits  (row_bits)
  );

  tile_xfer_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cmd_fire && !shape_bad),
    .base      (cmd_base),
    .stride_in (cmd_stride),
    .step      (row_step),
    .addr      (row_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= OP_LOAD;
      tile_q <= '0;
      rows_q <= '0;
      bpr_q  <= '0;
      row_q  <= '0;
      wbuf   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state)
        ST_IDLE: if (cmd_fire) begin
          if (shape_bad) begin
            err_q <= 1'b1;
          end else begin
            op_q   <= cmd_op_e;
            tile_q <= cmd_tile;
            rows_q <= cfg_rows;
            bpr_q  <= cfg_bytes;
            row_q  <= '0;
            unique case (cmd_op_e)
              OP_LOAD, OP_LOAD_NT: begin
                if (cfg_rows < RCNT_W'(MAX_ROWS)) begin
                  row_q <= cfg_rows[ROW_W-1:0];
                  state <= ST_FILL;
                end else begin
                  state <= ST_REQ;
                end
              end
              OP_STORE: state <= ST_RD;
              default:  state <= ST_CLR;
            endcase
          end
        end
        ST_FILL: begin
          if (row_q == ROW_LAST) begin
            row_q <= '0;
            state <= ST_REQ;
          end else begin
            row_q <= row_q + 1'b1;
          end
        end
        ST_REQ: if (req_fire) state <= ST_WAIT;
        ST_WAIT: if (rsp_take) begin
          if (last_row) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            row_q <= row_q + 1'b1;
            state <= ST_REQ;
          end
        end
        ST_RD:  state <= ST_LAT;
        ST_LAT: begin
          wbuf  <= tf_rd_data & row_bits;
          state <= ST_SWR;
        end
        ST_SWR: if (req_fire) begin
          if (last_row) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            row_q <= row_q + 1'b1;
            state <= ST_RD;
          end
        end
        ST_CLR: begin
          if (last_row) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            row_q <= row_q + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == ST_REQ) || (state == ST_SWR);
  assign mem_req_write = (state == ST_SWR);
  assign mem_req_hint  = (state == ST_REQ) && (op_q == OP_LOAD_NT);
  assign mem_req_addr  = row_addr;
  assign mem_req_be    = row_be;
  assign mem_req_wdata = wbuf;

  assign tf_wr_en   = (state == ST_FILL) || (state == ST_CLR) || rsp_take;
  assign tf_wr_tile = tile_q;
  assign tf_wr_row  = row_q;
  assign tf_wr_data = (state == ST_WAIT) ? (mem_rsp_data & row_bits) : '0;
  assign tf_rd_en   = (state == ST_RD);
  assign tf_rd_tile = tile_q;
  assign tf_rd_row  = row_q;

  assign xfer_done = done_q;
  assign xfer_err  = err_q;

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_wdata) && $stable(mem_req_be) && $stable(mem_req_write));

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> !mem_req_valid && !tf_wr_en && !xfer_done);

  assert_busy_ports_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || tf_wr_en || tf_rd_en) |-> !cmd_ready);

  assert_one_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tf_wr_en, tf_rd_en, mem_req_valid}));

  assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> $past(rsp_take || req_fire || tf_wr_en));

  assert_store_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> (mem_req_wdata & ~row_bits) == '0);

  assert_clear_no_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CLR) |-> !mem_req_valid && (op_q == OP_ZERO));

  assert_be_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> $countones(mem_req_be) == int'(bpr_q));

endmodule

// File: tb/tile_xfer_engine_bench.sv
module tile_xfer_engine_bench;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  tile;
    logic [31:0] base;
    logic [31:0] stride;
    logic [4:0]  rows;
    logic [6:0]  bpr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd1, 32'h0000_1000, 32'h0000_0040, 5'd16, 7'd64},
    '{2'd0, 3'd2, 32'h0000_2000, 32'h0000_0100, 5'd5,  7'd17},
    '{2'd1, 3'd3, 32'h0000_3004, 32'h0000_0080, 5'd3,  7'd64},
    '{2'd2, 3'd1, 32'h0000_8000, 32'h0000_0044, 5'd16, 7'd64},
    '{2'd2, 3'd4, 32'h0000_9000, 32'h0000_0200, 5'd7,  7'd1},
    '{2'd3, 3'd5, 32'h0000_0000, 32'h0000_0000, 5'd4,  7'd30},
    '{2'd0, 3'd6, 32'hFFFF_FF00, 32'h0000_0080, 5'd4,  7'd8},
    '{2'd0, 3'd0, 32'h0000_7700, 32'h0000_0000, 5'd1,  7'd64}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid, cmd_ready;
  logic [1:0]   cmd_op;
  logic [2:0]   cmd_tile;
  logic [31:0]  cmd_base, cmd_stride;
  logic         cfg_valid;
  logic [4:0]   cfg_rows;
  logic [6:0]   cfg_bytes;
  logic         mem_req_valid, mem_req_ready, mem_req_write, mem_req_hint;
  logic [31:0]  mem_req_addr;
  logic [63:0]  mem_req_be;
  logic [511:0] mem_req_wdata;
  logic         mem_rsp_valid;
  logic [511:0] mem_rsp_data;
  logic         tf_wr_en, tf_rd_en;
  logic [2:0]   tf_wr_tile, tf_rd_tile;
  logic [3:0]   tf_wr_row, tf_rd_row;
  logic [511:0] tf_wr_data, tf_rd_data;
  logic         xfer_done, xfer_err;

  always #10 clk = ~clk;  // 50 MHz

  tile_xfer_engine u_tile_xfer_engine (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_tile(cmd_tile),
    .cmd_base(cmd_base), .cmd_stride(cmd_stride),
    .cfg_valid(cfg_valid), .cfg_rows(cfg_rows), .cfg_bytes(cfg_bytes),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_hint(mem_req_hint),
    .mem_req_addr(mem_req_addr), .mem_req_be(mem_req_be), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .tf_wr_en(tf_wr_en), .tf_wr_tile(tf_wr_tile), .tf_wr_row(tf_wr_row), .tf_wr_data(tf_wr_data),
    .tf_rd_en(tf_rd_en), .tf_rd_tile(tf_rd_tile), .tf_rd_row(tf_rd_row), .tf_rd_data(tf_rd_data),
    .xfer_done(xfer_done), .xfer_err(xfer_err)
  );

  int checks = 0;
  int errors = 0;

  function automatic logic [511:0] pat(input logic [31:0] a);
    logic [511:0] d;
    for (int i = 0; i < 64; i++) begin
      d[i*8 +: 8] = a[7:0] + (a[15:8] * 8'd3) + (a[23:16] * 8'd5) + (a[31:24] * 8'd7)
                    + 8'(i * 13 + 1);
    end
    return d;
  endfunction

  function automatic logic [63:0] be_of(input logic [6:0] n);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  function automatic logic [511:0] bits_of(input logic [6:0] n);
    logic [511:0] m;
    for (int i = 0; i < 64; i++) m[i*8 +: 8] = (i < int'(n)) ? 8'hFF : 8'h00;
    return m;
  endfunction

  // tile register file model, written only here
  logic [511:0] tarr [8][16];
  logic         bk_we = 1'b0;
  logic [2:0]   bk_tile = '0;
  logic [3:0]   bk_row = '0;
  logic [511:0] bk_data = '0;
  int pc = 0;
  int last_evt = -10;

  always @(posedge clk) begin
    pc <= pc + 1;
    if ((mem_req_valid && mem_req_ready) || mem_rsp_valid || tf_wr_en) last_evt <= pc + 1;
    if (tf_wr_en) tarr[tf_wr_tile][tf_wr_row] <= tf_wr_data;
    else if (bk_we) tarr[bk_tile][bk_row] <= bk_data;
    if (tf_rd_en) tf_rd_data <= tarr[tf_rd_tile][tf_rd_row];
  end

  // memory model with backpressure and response delay
  logic [15:0]  lfsr;
  logic         rdy, pend, hv_prev;
  logic [1:0]   pend_dly;
  logic [31:0]  pend_addr, hv_addr;
  logic [511:0] hv_data;
  int hold_viol = 0;
  int log_cnt = 0;
  logic [31:0]  lg_addr [256];
  logic [63:0]  lg_be   [256];
  logic [511:0] lg_data [256];
  logic         lg_wr   [256];
  logic         lg_hint [256];

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      pend          <= 1'b0;
      pend_dly      <= '0;
      pend_addr     <= '0;
      hv_prev       <= 1'b0;
      hv_addr       <= '0;
      hv_data       <= '0;
      lfsr          <= 16'hACE1;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy = lfsr[0] | lfsr[3];
      if (hv_prev && !(mem_req_valid && mem_req_addr == hv_addr && mem_req_wdata == hv_data))
        hold_viol = hold_viol + 1;
      hv_prev <= mem_req_valid && !rdy;
      hv_addr <= mem_req_addr;
      hv_data <= mem_req_wdata;
      mem_req_ready <= rdy;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && rdy) begin
        if (log_cnt < 256) begin
          lg_addr[log_cnt] = mem_req_addr;
          lg_be[log_cnt]   = mem_req_be;
          lg_data[log_cnt] = mem_req_wdata;
          lg_wr[log_cnt]   = mem_req_write;
          lg_hint[log_cnt] = mem_req_hint;
        end
        log_cnt = log_cnt + 1;
        if (!mem_req_write) begin
          pend      <= 1'b1;
          pend_addr <= mem_req_addr;
          pend_dly  <= lfsr[5:4];
        end
      end else if (pend) begin
        if (pend_dly == 2'd0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= pat(pend_addr);
          pend          <= 1'b0;
        end else begin
          pend_dly <= pend_dly - 2'd1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [511:0] act,
                       input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bk_write(input logic [2:0] t, input int r, input logic [511:0] d);
    @(negedge clk);
    bk_we = 1'b1; bk_tile = t; bk_row = 4'(r); bk_data = d;
    @(negedge clk);
    bk_we = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [2:0] t, input logic [31:0] b,
                       input logic [31:0] s, input logic [4:0] rows, input logic [6:0] bpr,
                       input logic cv);
    @(negedge clk);
    cfg_valid = cv; cfg_rows = rows; cfg_bytes = bpr;
    cmd_op = op; cmd_tile = t; cmd_base = b; cmd_stride = s; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    bit seen = 0;
    int n = 0;
    while (!seen && n < 4000) begin
      if (xfer_done) begin
        seen = 1;
        check(last_evt == pc, "R9 done one cycle after last event", 512'(last_evt), 512'(pc));
      end else begin
        @(negedge clk);
        n++;
      end
    end
    check(seen, "R9 done pulse seen", 512'(seen), 512'(1));
    @(negedge clk);
    check(!xfer_done, "R9 done lasts one cycle", 512'(xfer_done), 512'(0));
  endtask

  task automatic run_vec(input vec_t v);
    int l0;
    logic [511:0] exp;
    for (int r = 0; r < 16; r++)
      bk_write(v.tile, r, (v.op == 2'd2) ? pat(32'hA000 + 32'(r) * 32'h10)
                                          : pat(32'h5555_0000 + 32'(r)));
    l0 = log_cnt;
    issue(v.op, v.tile, v.base, v.stride, v.rows, v.bpr, 1'b1);
    wait_done();
    if (v.op == 2'd3) begin
      check(log_cnt == l0, "R7 clear makes no memory request", 512'(log_cnt - l0), 512'(0));
      for (int r = 0; r < 16; r++) begin
        exp = (r < int'(v.rows)) ? 512'(0) : pat(32'h5555_0000 + 32'(r));
        check(tarr[v.tile][r] == exp, "R7 clear tile row", tarr[v.tile][r], exp);
      end
    end else begin
      check(log_cnt - l0 == int'(v.rows), (v.op == 2'd2) ? "R6 write count" : "R2 read count",
            512'(log_cnt - l0), 512'(v.rows));
      for (int k = 0; k < int'(v.rows); k++) begin
        logic [31:0] ea = v.base + 32'(k) * v.stride;  // wraps per R12
        check(lg_addr[l0+k] == ea, "R2 R12 row address", 512'(lg_addr[l0+k]), 512'(ea));
        check(lg_be[l0+k] == be_of(v.bpr), "R2 byte enables", 512'(lg_be[l0+k]),
              512'(be_of(v.bpr)));
        check(lg_wr[l0+k] == (v.op == 2'd2), "R2 R6 direction", 512'(lg_wr[l0+k]),
              512'(v.op == 2'd2));
        check(lg_hint[l0+k] == (v.op == 2'd1), "R5 reuse hint", 512'(lg_hint[l0+k]),
              512'(v.op == 2'd1));
        if (v.op == 2'd2) begin
          exp = pat(32'hA000 + 32'(k) * 32'h10) & bits_of(v.bpr);
          check(lg_data[l0+k] == exp, "R6 store data", lg_data[l0+k], exp);
        end
      end
      if (v.op != 2'd2) begin
        for (int r = 0; r < 16; r++) begin
          if (r < int'(v.rows)) begin
            exp = pat(v.base + 32'(r) * v.stride) & bits_of(v.bpr);
            check(tarr[v.tile][r] == exp, "R3 loaded row", tarr[v.tile][r], exp);
          end else begin
            check(tarr[v.tile][r] == 512'(0), "R4 tail row zero", tarr[v.tile][r], 512'(0));
          end
        end
      end
    end
  endtask

  initial begin
    wait (pc > 150000);
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    int l0;
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_op = '0; cmd_tile = '0; cmd_base = '0; cmd_stride = '0;
    cfg_valid = 1'b0; cfg_rows = '0; cfg_bytes = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cmd_ready && !mem_req_valid && !tf_wr_en && !tf_rd_en && !xfer_done && !xfer_err,
          "R1 reset outputs", 512'({cmd_ready, mem_req_valid, tf_wr_en, tf_rd_en, xfer_done, xfer_err}),
          512'(6'b100000));
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && !mem_req_valid && !tf_wr_en && !xfer_done && !xfer_err,
          "R1 first cycle after reset", 512'({cmd_ready, mem_req_valid, tf_wr_en, xfer_done, xfer_err}),
          512'(5'b10000));

    for (int v = 0; v < NV; v++) run_vec(VECS[v]);

    // R8: unconfigured, then zero-row shape
    for (int t = 0; t < 2; t++) begin
      for (int r = 0; r < 16; r++) bk_write(3'd0, r, pat(32'h6600 + 32'(r)));
      l0 = log_cnt;
      issue(2'd3, 3'd0, 32'h100, 32'h40, (t == 0) ? 5'd16 : 5'd0, 7'd64, (t == 0) ? 1'b0 : 1'b1);
      check(xfer_err, "R8 error pulse after refusal", 512'(xfer_err), 512'(1));
      @(negedge clk);
      check(!xfer_err, "R8 error lasts one cycle", 512'(xfer_err), 512'(0));
      for (int n = 0; n < 20; n++) begin
        if (xfer_done) check(0, "R8 no done after refusal", 512'(1), 512'(0));
        @(negedge clk);
      end
      check(log_cnt == l0, "R8 no memory traffic", 512'(log_cnt - l0), 512'(0));
      for (int r = 0; r < 16; r++)
        check(tarr[0][r] == pat(32'h6600 + 32'(r)), "R8 tile untouched", tarr[0][r],
              pat(32'h6600 + 32'(r)));
    end

    // R11: command offered while busy is ignored
    for (int r = 0; r < 16; r++) bk_write(3'd0, r, pat(32'h7100 + 32'(r)));
    l0 = log_cnt;
    issue(2'd0, 3'd2, 32'h4000, 32'h40, 5'd4, 7'd64, 1'b1);
    for (int n = 0; n < 3; n++) begin
      cmd_op = 2'd3; cmd_tile = 3'd0; cmd_valid = 1'b1;
      check(!cmd_ready, "R11 not ready while busy", 512'(cmd_ready), 512'(0));
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    wait_done();
    repeat (10) @(negedge clk);
    check(log_cnt - l0 == 4, "R11 only the running command's requests", 512'(log_cnt - l0), 512'(4));
    for (int r = 0; r < 16; r++)
      check(tarr[0][r] == pat(32'h7100 + 32'(r)), "R11 offered clear had no effect", tarr[0][r],
            pat(32'h7100 + 32'(r)));

    check(hold_viol == 0, "R10 stalled request held", 512'(hold_viol), 512'(0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule